// File: doc/BRIEF.md
# Receive Word Assembler with Split Host Readout

This block sits behind a bit validator on one serial receive channel. Each validated bit arrives as a one-cycle strobe with its value, first word bit first. After thirty-two strobes in a row with no intervening error, the assembled word is complete. At that point the block computes a parity result and, when filtering is switched on, compares two word bits against programmed values. A word that passes is held in a holding register, and an active-low ready flag is asserted.

A host fetches the held word over a 16-bit bus in two halves, using an active-low enable strobe and a half-select input. The ready flag returns high only once both halves have been fetched, in either order. A newer accepted word replaces an unread one without warning. An error pulse from the validator discards the partial word and leaves the held word untouched.

The block has two state machines. The collector has two states: COLLECT, which counts strobes, and COMPLETE, a one-cycle end-of-word state. COLLECT moves to COMPLETE on the thirty-second strobe, and COMPLETE always returns to COLLECT. The readout machine has four states: EMPTY, FULL, GOT_LO (half 1 already fetched) and GOT_HI (half 2 already fetched). An accepted word moves any state to FULL. A fetch of one half moves FULL to GOT_LO or GOT_HI. A fetch of the other half moves GOT_LO or GOT_HI to EMPTY. A repeated fetch of the same half keeps the state.

Top module: `rx_word_assembler`

## Requirements
- R1: Word bit 1 is the first strobed bit. It appears on bus bit 7 of half 1.
- R2: A word completes on its thirty-second error-free strobe. `ready_n` goes low two clock edges after the edge that samples that strobe.
- R3: Bus bit 8 of half 1 holds the parity result. It is 1 when the count of ones over all 32 received bits is even, and 0 when the count is odd.
- R4: With `filt_en` high, a word is accepted only if word bit 9 equals `match_a` and word bit 10 equals `match_b`. A rejected word leaves `ready_n` and the held word unchanged. With `filt_en` low, every word is accepted.
- R5: `ready_n` stays low until both halves have been fetched, in either order. It rises right after the second distinct fetch.
- R6: Fetching the same half twice does not count as fetching the other half.
- R7: An accepted word that completes before both halves are fetched overwrites the held word. It also restarts the fetch tracking.
- R8: Half 1 (`half_sel` = 0) has the following layout:
  - bus bits 15..11 carry word bits 13, 12, 11, 10, 9;
  - bus bit 10 carries word bit 31;
  - bus bit 9 carries word bit 30;
  - bus bit 8 carries the parity result;
  - bus bits 7..0 carry word bits 1..8.
- R9: Half 2 (`half_sel` = 1) carries word bits 29 down to 14 on bus bits 15 down to 0.
- R10: A `bit_err` pulse restarts the bit count at word bit 1. It has no effect on `ready_n` or on the held word.
- R11: `rd_data` is zero while `rd_en_n` is high.
- R12: After reset, `ready_n` is high and the bit count is at word bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe for a validated bit |
| bit_val | input | 1 | Value of the strobed bit |
| bit_err | input | 1 | Validator error pulse; discards the partial word |
| filt_en | input | 1 | Enables the word-bit 9/10 filter |
| match_a | input | 1 | Required value of word bit 9 |
| match_b | input | 1 | Required value of word bit 10 |
| rd_en_n | input | 1 | Host read enable, active low; a fetch counts on its release |
| half_sel | input | 1 | 0 selects half 1, 1 selects half 2 |
| rd_data | output | 16 | Selected half while enabled, zero otherwise |
| ready_n | output | 1 | Low while an accepted word has not been fully fetched |

## Verification
`ready_n` falls two edges after the edge that samples the thirty-second strobe: one edge latches the candidate word, and the next loads the holding register. The bench therefore samples it on the second falling edge after it drives that strobe. It also checks that the flag is still high one falling edge earlier.

`rd_data` is combinational from the held word, so the bench reads it during the low half of the enable pulse. A fetch counts on the edge that sees the enable released. The bench checks the flag at the falling edge after the one where it raised `rd_en_n`.

Every expected half is assembled in the bench from the sent word by the bus layouts in R8 and R9 and the parity rule in R3.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic {
        CS_COLLECT  = 1'b0,
        CS_COMPLETE = 1'b1
    } coll_state_t;

    typedef enum logic [1:0] {
        RS_EMPTY  = 2'd0,
        RS_FULL   = 2'd1,
        RS_GOT_LO = 2'd2,
        RS_GOT_HI = 2'd3
    } rd_state_t;
endpackage

// File: rtl/rxw_collect.sv
module rxw_collect
    import rxw_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_stb,
    input  logic         bit_val,
    input  logic         bit_err,
    output logic         eos,
    output logic [W-1:0] cand
);
    localparam int CNT_W = $clog2(W);

    coll_state_t        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [W-2:0]       shreg_q;
    logic               good_stb;
    logic               last_bit;

    always_comb begin
        good_stb = bit_stb && !bit_err;
        last_bit = good_stb && (cnt_q == CNT_W'(W - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_COLLECT:  state_d = last_bit ? CS_COMPLETE : CS_COLLECT;
            CS_COMPLETE: state_d = CS_COLLECT;
            default:     state_d = CS_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_COLLECT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_err) begin
            cnt_q <= '0;
        end else if (bit_stb) begin
            cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else begin
            for (int k = 0; k < W - 1; k++) begin
                if (good_stb && (cnt_q == CNT_W'(k))) shreg_q[k] <= bit_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cand <= '0;
        else if (last_bit) cand <= {bit_val, shreg_q};
    end

    always_comb eos = (state_q == CS_COMPLETE);

    assert_eos_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> $past(bit_stb && !bit_err));

    assert_err_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |=> (cnt_q == '0));
endmodule

// File: rtl/rxw_check.sv
module rxw_check
    import rxw_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int FILT_A = 8,
    parameter int FILT_B = 9
) (
    input  logic         eos,
    input  logic [W-1:0] cand,
    input  logic         filt_en,
    input  logic         match_a,
    input  logic         match_b,
    output logic         accept,
    output logic [W-1:0] word_fix
);
    logic parity_bit;
    logic label_ok;

    always_comb begin
        parity_bit = ~(^cand);
        label_ok   = (cand[FILT_A] == match_a) && (cand[FILT_B] == match_b);
        accept     = eos && (!filt_en || label_ok);
        word_fix   = {parity_bit, cand[W-2:0]};
    end
endmodule

// File: rtl/rxw_readout.sv
module rxw_readout
    import rxw_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int H = HALF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word_in,
    input  logic         rd_en_n,
    input  logic         half_sel,
    output logic [H-1:0] rd_data,
    output logic         ready_n
);
    localparam int LSB_W = 8;

    rd_state_t    state_q, state_d;
    logic [W-1:0] held_q;
    logic         en_q;
    logic         release_evt;
    logic [H-1:0] half_lo, half_hi;

    always_comb release_evt = rd_en_n && !en_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = RS_FULL;
        end else if (release_evt) begin
            unique case (state_q)
                RS_EMPTY:  state_d = RS_EMPTY;
                RS_FULL:   state_d = half_sel ? RS_GOT_HI : RS_GOT_LO;
                RS_GOT_LO: state_d = half_sel ? RS_EMPTY : RS_GOT_LO;
                RS_GOT_HI: state_d = half_sel ? RS_GOT_HI : RS_EMPTY;
                default:   state_d = RS_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
            en_q   <= 1'b1;
        end else begin
            en_q <= rd_en_n;
            if (load) held_q <= word_in;
        end
    end

    // half 1: first eight bits reversed in the low byte
    generate
        for (genvar i = 0; i < LSB_W; i++) begin : g_lsb
            assign half_lo[LSB_W-1-i] = held_q[i];
        end
        for (genvar j = 0; j < 5; j++) begin : g_label_hi
            assign half_lo[11+j] = held_q[8+j];
        end
        for (genvar k = 0; k < H; k++) begin : g_hi
            assign half_hi[k] = held_q[13+k];
        end
    endgenerate
    assign half_lo[8]  = held_q[31];
    assign half_lo[9]  = held_q[29];
    assign half_lo[10] = held_q[30];

    always_comb begin
        ready_n = (state_q == RS_EMPTY);
        if (rd_en_n)       rd_data = '0;
        else if (half_sel) rd_data = half_hi;
        else               rd_data = half_lo;
    end

    assert_ready_falls_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(load));

    assert_ready_rises_on_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(release_evt));

    assert_held_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q));
endmodule

// File: rtl/rx_word_assembler.sv
module rx_word_assembler
    import rxw_pkg::*;
#(
    parameter int FILT_A = 8,
    parameter int FILT_B = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              bit_err,
    input  logic              filt_en,
    input  logic              match_a,
    input  logic              match_b,
    input  logic              rd_en_n,
    input  logic              half_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              ready_n
);
    logic              eos;
    logic [WORD_W-1:0] cand;
    logic              accept;
    logic [WORD_W-1:0] word_fix;

    rxw_collect #(.W(WORD_W)) u_collect (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .bit_err(bit_err), .eos(eos), .cand(cand)
    );

    rxw_check #(.W(WORD_W), .FILT_A(FILT_A), .FILT_B(FILT_B)) u_check (
        .eos(eos), .cand(cand), .filt_en(filt_en), .match_a(match_a),
        .match_b(match_b), .accept(accept), .word_fix(word_fix)
    );

    rxw_readout #(.W(WORD_W), .H(HALF_W)) u_readout (
        .clk(clk), .rst_n(rst_n), .load(accept), .word_in(word_fix),
        .rd_en_n(rd_en_n), .half_sel(half_sel), .rd_data(rd_data), .ready_n(ready_n)
    );

    assert_parity_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (word_fix[WORD_W-1] == ~(^cand)) || (WORD_W != 32));
endmodule

// File: tb/rx_word_assembler_bench.sv
module rx_word_assembler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0, bit_val = 1'b0, bit_err = 1'b0;
    logic        filt_en = 1'b0, match_a = 1'b0, match_b = 1'b0;
    logic        rd_en_n = 1'b1, half_sel = 1'b0;
    logic [15:0] rd_data;
    logic        ready_n;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    rx_word_assembler u_rx_word_assembler (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .bit_err(bit_err), .filt_en(filt_en), .match_a(match_a), .match_b(match_b),
        .rd_en_n(rd_en_n), .half_sel(half_sel), .rd_data(rd_data), .ready_n(ready_n)
    );

    function automatic logic [31:0] fixw(input logic [31:0] w);
        return {~(^w), w[30:0]};
    endfunction

    function automatic logic [15:0] exp_lo(input logic [31:0] w);
        logic [31:0] f = fixw(w);
        logic [7:0]  r;
        for (int i = 0; i < 8; i++) r[7-i] = f[i];
        return {f[12:8], f[30], f[29], f[31], r};
    endfunction

    function automatic logic [15:0] exp_hi(input logic [31:0] w);
        return w[28:13];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_stb = 1'b1; bit_val = w[i];
            @(negedge clk); bit_stb = 1'b0; bit_val = 1'b0;
        end
    endtask

    // last strobe sampled at the edge before the current negedge; ready due one edge later
    task automatic send_word(input logic [31:0] w, input logic was_ready_n);
        send_bits(w, 31);
        @(negedge clk); bit_stb = 1'b1; bit_val = w[31];
        @(negedge clk); bit_stb = 1'b0; bit_val = 1'b0;
        chk("R2 ready not yet", {31'd0, ready_n}, {31'd0, was_ready_n});
        @(negedge clk);
    endtask

    task automatic fetch(input logic sel, output logic [15:0] d);
        @(negedge clk); half_sel = sel; rd_en_n = 1'b0;
        @(negedge clk); d = rd_data; rd_en_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_err();
        @(negedge clk); bit_err = 1'b1;
        @(negedge clk); bit_err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [31:0] w;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset ready_n", {31'd0, ready_n}, 32'd1);
        chk("R11 idle data", {16'd0, rd_data}, 32'd0);

        // sweep of walking ones plus dense patterns, both fetch orders
        for (int p = 0; p < 36; p++) begin
            if (p < 32) w = 32'd1 << p;
            else if (p == 32) w = 32'h0000_0000;
            else if (p == 33) w = 32'hFFFF_FFFF;
            else if (p == 34) w = 32'hA5C3_5A3C;
            else w = 32'h1234_8765;
            send_word(w, 1'b1);
            chk("R2 ready low after word", {31'd0, ready_n}, 32'd0);
            chk("R11 data idle with ready", {16'd0, rd_data}, 32'd0);
            if (p[0] == 1'b0) begin
                fetch(1'b0, d);
                chk("R8 half1 layout", {16'd0, d}, {16'd0, exp_lo(w)});
                chk("R1 first bit on bus7", {31'd0, d[7]}, {31'd0, w[0]});
                chk("R3 parity on bus8", {31'd0, d[8]}, {31'd0, ~(^w)});
                chk("R5 ready after one half", {31'd0, ready_n}, 32'd0);
                fetch(1'b1, d);
                chk("R9 half2 layout", {16'd0, d}, {16'd0, exp_hi(w)});
            end else begin
                fetch(1'b1, d);
                chk("R9 half2 layout", {16'd0, d}, {16'd0, exp_hi(w)});
                chk("R5 ready after one half", {31'd0, ready_n}, 32'd0);
                fetch(1'b0, d);
                chk("R8 half1 layout", {16'd0, d}, {16'd0, exp_lo(w)});
                chk("R3 parity on bus8", {31'd0, d[8]}, {31'd0, ~(^w)});
            end
            chk("R5 ready high after both", {31'd0, ready_n}, 32'd1);
        end

        // filter sweep: programmed pair against word bits 9 and 10 (indices 8, 9)
        filt_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                match_a = m[0]; match_b = m[1];
                w = 32'h3C0F_F0C3;
                w[8] = b[0]; w[9] = b[1];
                send_word(w, 1'b1);
                chk("R4 filter decision", {31'd0, ready_n}, {31'd0, (m != b)});
                if (m == b) begin
                    fetch(1'b0, d);
                    chk("R4 accepted half1", {16'd0, d}, {16'd0, exp_lo(w)});
                    fetch(1'b1, d);
                end
            end
        end
        // rejected word leaves held word intact
        match_a = 1'b0; match_b = 1'b0;
        a = 32'h0000_0055;
        send_word(a, 1'b1);
        send_word(32'h0000_0355, 1'b0);
        fetch(1'b0, d);
        chk("R4 rejected word no effect", {16'd0, d}, {16'd0, exp_lo(a)});
        fetch(1'b1, d);
        filt_en = 1'b0; match_a = 1'b1; match_b = 1'b1;
        send_word(32'h0000_0000, 1'b1);
        chk("R4 filter off accepts", {31'd0, ready_n}, 32'd0);
        fetch(1'b0, d); fetch(1'b1, d);

        // overwrite of an unread word
        send_word(32'hDEAD_BEEF, 1'b1);
        send_word(32'h0BAD_F00D, 1'b0);
        fetch(1'b0, d);
        chk("R7 overwrite half1", {16'd0, d}, {16'd0, exp_lo(32'h0BAD_F00D)});
        fetch(1'b1, d);
        chk("R7 overwrite half2", {16'd0, d}, {16'd0, exp_hi(32'h0BAD_F00D)});
        chk("R7 ready high", {31'd0, ready_n}, 32'd1);

        // overwrite restarts fetch tracking
        send_word(32'h1111_2222, 1'b1);
        fetch(1'b0, d);
        send_word(32'h3333_4444, 1'b0);
        fetch(1'b1, d);
        chk("R7 tracking restarted", {31'd0, ready_n}, 32'd0);
        fetch(1'b0, d);
        chk("R7 new word half1", {16'd0, d}, {16'd0, exp_lo(32'h3333_4444)});
        chk("R7 ready high after both", {31'd0, ready_n}, 32'd1);

        // same half twice
        send_word(32'h5555_AAAA, 1'b1);
        fetch(1'b0, d); fetch(1'b0, d);
        chk("R6 same half twice", {31'd0, ready_n}, 32'd0);
        fetch(1'b1, d); fetch(1'b1, d);
        chk("R6 half2 completes", {31'd0, ready_n}, 32'd1);
        send_word(32'h0F0F_0F0F, 1'b1);
        fetch(1'b1, d); fetch(1'b1, d);
        chk("R6 same half2 twice", {31'd0, ready_n}, 32'd0);
        fetch(1'b0, d);
        chk("R6 half1 completes", {31'd0, ready_n}, 32'd1);

        // validator error discards partial word
        send_bits(32'hFFFF_FFFF, 12);
        pulse_err();
        chk("R10 err no ready", {31'd0, ready_n}, 32'd1);
        w = 32'h8421_1248;
        send_word(w, 1'b1);
        chk("R10 word after err", {31'd0, ready_n}, 32'd0);
        pulse_err();
        chk("R10 err keeps ready", {31'd0, ready_n}, 32'd0);
        fetch(1'b0, d);
        chk("R10 held half1 intact", {16'd0, d}, {16'd0, exp_lo(w)});
        fetch(1'b1, d);
        chk("R10 held half2 intact", {16'd0, d}, {16'd0, exp_hi(w)});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule